// File: doc/BRIEF.md
# Conditional Thread Context Allocator

This block owns the pool of hardware thread contexts of a multithreaded core. Decode raises a spawn request on behalf of a running thread. The allocator answers in the same cycle. It either grants the request and names a free context, or it leaves the grant low so that the spawn behaves as a no-op. A granted context is reserved in a non-fetching state. When the spawn instruction retires, the context becomes live and a register-copy request goes out to the copy datapath. If the spawn is squashed instead, the reservation is dropped.

Kill instructions follow a similar two-step path. At decode the thread stops fetching, and at commit its context is released. Every release at commit counts as a thread death. The allocator keeps a running count of deaths over a sliding window of recent cycles. When too many threads have died recently, it refuses new spawns even if contexts are free. This stops the program from dividing work into pieces too small to repay the creation cost.

Top module: `ctx_alloc`

## Requirements
- R1: After reset, context 0 is active and fetching, every other context is free, `fetch_en` reads 0x01, and `copy_req` is low.
- R2: A spawn is granted only when at least one context is free. The context handed out on `gnt_ctx` is the free context with the lowest index.
- R3: At most one spawn is granted per cycle. `spawn_req`/`spawn_gnt` bit i belongs to thread i. When several threads request at once, the lowest-numbered requester is granted and the others see a zero grant bit (denied).
- R4: A granted context moves from free to stall. It does not fetch, and it is no longer offered as free.
- R5: On spawn retirement for context c, c becomes active. In the following cycle, `copy_req` is high for exactly one cycle, with `copy_dst`=c, `copy_src`=the thread that requested the spawn, and `copy_pc`=the retired target address.
- R6: The parent thread named on `copy_src` has its `fetch_en` bit low during the `copy_req` cycle and high again in the next cycle.
- R7: Squashing a reserved context returns it to free, and it can be granted again.
- R8: On kill decode, the named context stops fetching at once in the next cycle.
- R9: On kill commit, the named context becomes free and can be granted again.
- R10: A spawn is denied while the number of kill commits in the last WIN (default 128) cycles is at least NCTX/2 (default 4). With 3 recent deaths, a spawn is still granted.
- R11: A death stops counting exactly WIN clock edges after the edge that recorded it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spawn_req | input | NCTX | Spawn decoded, one bit per requesting thread |
| spawn_gnt | output | NCTX | One-hot grant to the served requester, zero when denied |
| gnt_ctx | output | IDW | Context reserved by the grant |
| ret_vld | input | 1 | A spawn instruction retires |
| ret_ctx | input | IDW | Child context of the retiring spawn |
| ret_pc | input | PCW | Branch target for the child |
| sq_vld | input | 1 | A spawn on a mispredicted path is squashed |
| sq_ctx | input | IDW | Context reserved by the squashed spawn |
| kdec_vld | input | 1 | Kill instruction decoded |
| kdec_ctx | input | IDW | Thread issuing the decoded kill |
| kcmt_vld | input | 1 | Kill instruction commits |
| kcmt_ctx | input | IDW | Thread whose kill commits |
| fetch_en | output | NCTX | Per-context fetch enable |
| copy_req | output | 1 | Register-copy request |
| copy_src | output | IDW | Parent context to copy from |
| copy_dst | output | IDW | Child context to copy into |
| copy_pc | output | PCW | Start address for the child |

## Verification
A corrupted context state appears on `fetch_en` one edge after the event that caused it. It also appears in the grant logic on the next spawn request, where a context that leaked or was lost changes which index is handed out. A wrong death count only shows up at the throttle boundary. For that reason the bench checks exactly three versus four recent deaths, and it checks the single cycle in which the oldest death leaves the window. A wrong parent record shows up as a bad `copy_src` and as the wrong `fetch_en` bit being held during the copy cycle.

// File: rtl/ctx_alloc.sv
module ctx_alloc #(
  parameter int NCTX = 8,
  parameter int WIN  = 128,
  parameter int PCW  = 32,
  localparam int IDW  = $clog2(NCTX),
  localparam int HALF = NCTX / 2,
  localparam int DW   = $clog2(WIN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCTX-1:0] spawn_req,
  output logic [NCTX-1:0] spawn_gnt,
  output logic [IDW-1:0]  gnt_ctx,
  input  logic            ret_vld,
  input  logic [IDW-1:0]  ret_ctx,
  input  logic [PCW-1:0]  ret_pc,
  input  logic            sq_vld,
  input  logic [IDW-1:0]  sq_ctx,
  input  logic            kdec_vld,
  input  logic [IDW-1:0]  kdec_ctx,
  input  logic            kcmt_vld,
  input  logic [IDW-1:0]  kcmt_ctx,
  output logic [NCTX-1:0] fetch_en,
  output logic            copy_req,
  output logic [IDW-1:0]  copy_src,
  output logic [IDW-1:0]  copy_dst,
  output logic [PCW-1:0]  copy_pc
);

  typedef enum logic [1:0] {S_FREE, S_STALL, S_ACT} cst_t;

  cst_t           st  [NCTX];
  logic [IDW-1:0] par [NCTX];
  logic [WIN-1:0] dwin;
  logic [DW-1:0]  dcnt;

  logic           fr_hit, rq_hit, ok;
  logic [IDW-1:0] fr_idx, rq_idx;
  logic [NCTX-1:0] act_v, stall_v, hold_v;

  always_comb begin
    fr_hit = 1'b0;
    fr_idx = '0;
    rq_hit = 1'b0;
    rq_idx = '0;
    for (int i = NCTX - 1; i >= 0; i--) begin
      if (st[i] == S_FREE) begin
        fr_hit = 1'b1;
        fr_idx = IDW'(i);
      end
      if (spawn_req[i]) begin
        rq_hit = 1'b1;
        rq_idx = IDW'(i);
      end
    end
  end

  assign ok        = fr_hit && rq_hit && (dcnt < DW'(HALF));
  assign spawn_gnt = ok ? (NCTX'(1) << rq_idx) : '0;
  assign gnt_ctx   = fr_idx;

  generate
    for (genvar g = 0; g < NCTX; g++) begin : g_vec
      assign act_v[g]   = (st[g] == S_ACT);
      assign stall_v[g] = (st[g] == S_STALL);
      assign hold_v[g]  = copy_req && (copy_src == IDW'(g));
    end
  endgenerate

  assign fetch_en = act_v & ~hold_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCTX; i++) begin
        st[i]  <= (i == 0) ? S_ACT : S_FREE;
        par[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NCTX; i++) begin
        if (ok && fr_idx == IDW'(i)) begin
          st[i]  <= S_STALL;
          par[i] <= rq_idx;
        end
        if (ret_vld && ret_ctx == IDW'(i))   st[i] <= S_ACT;
        if (sq_vld && sq_ctx == IDW'(i))     st[i] <= S_FREE;
        if (kdec_vld && kdec_ctx == IDW'(i)) st[i] <= S_STALL;
        if (kcmt_vld && kcmt_ctx == IDW'(i)) st[i] <= S_FREE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      copy_req <= 1'b0;
      copy_src <= '0;
      copy_dst <= '0;
      copy_pc  <= '0;
    end else begin
      copy_req <= ret_vld;
      copy_dst <= ret_ctx;
      copy_src <= par[ret_ctx];
      copy_pc  <= ret_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dwin <= '0;
      dcnt <= '0;
    end else begin
      dwin <= {dwin[WIN-2:0], kcmt_vld};
      dcnt <= dcnt + DW'(kcmt_vld) - DW'(dwin[WIN-1]);
    end
  end

  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(spawn_gnt));

  // R4
  grant_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|spawn_gnt && !ret_vld && !sq_vld && !kdec_vld && !kcmt_vld) |=> stall_v[$past(gnt_ctx)]);

  // R5
  copy_child_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_vld |=> (copy_req && act_v[copy_dst]));

  // R6
  parent_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    copy_req |-> !fetch_en[copy_src]);

  // R11
  window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt <= DW'(WIN));

  // R10
  throttle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dcnt >= DW'(HALF)) |-> (spawn_gnt == '0));

endmodule

// File: tb/sim_ctx_alloc.sv
`timescale 1ns/1ps
module sim_ctx_alloc;
  localparam int NCTX = 8;
  localparam int IDW  = 3;
  localparam int PCW  = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCTX-1:0] spawn_req, spawn_gnt, fetch_en;
  logic [IDW-1:0]  gnt_ctx, ret_ctx, sq_ctx, kdec_ctx, kcmt_ctx, copy_src, copy_dst;
  logic [PCW-1:0]  ret_pc, copy_pc;
  logic ret_vld, sq_vld, kdec_vld, kcmt_vld, copy_req;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ctx_alloc u0 (
    .clk(clk), .rst_n(rst_n),
    .spawn_req(spawn_req), .spawn_gnt(spawn_gnt), .gnt_ctx(gnt_ctx),
    .ret_vld(ret_vld), .ret_ctx(ret_ctx), .ret_pc(ret_pc),
    .sq_vld(sq_vld), .sq_ctx(sq_ctx),
    .kdec_vld(kdec_vld), .kdec_ctx(kdec_ctx),
    .kcmt_vld(kcmt_vld), .kcmt_ctx(kcmt_ctx),
    .fetch_en(fetch_en), .copy_req(copy_req), .copy_src(copy_src),
    .copy_dst(copy_dst), .copy_pc(copy_pc)
  );

  // rows: {spawn_req, expected spawn_gnt, expected gnt_ctx}
  localparam logic [18:0] VEC [9] = '{
    {8'h01, 8'h01, 3'd1},
    {8'h06, 8'h02, 3'd2},
    {8'h00, 8'h00, 3'd0},
    {8'h81, 8'h01, 3'd3},
    {8'h10, 8'h10, 3'd4},
    {8'h01, 8'h01, 3'd5},
    {8'h40, 8'h40, 3'd6},
    {8'h01, 8'h01, 3'd7},
    {8'h01, 8'h00, 3'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    spawn_req = '0; ret_vld = 0; sq_vld = 0; kdec_vld = 0; kcmt_vld = 0;
    ret_ctx = '0; sq_ctx = '0; kdec_ctx = '0; kcmt_ctx = '0; ret_pc = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    step();
    step();
    rst_n = 1;
  endtask

  task automatic spawn_chk(input string tag, input logic [7:0] req,
                           input logic [7:0] eg, input logic [2:0] ec);
    spawn_req = req;
    #1;
    chk({tag, " gnt"}, 32'(spawn_gnt), 32'(eg));
    if (eg != 0) chk({tag, " ctx"}, 32'(gnt_ctx), 32'(ec));
    step();
  endtask

  task automatic kill_commit(input logic [2:0] c);
    kcmt_vld = 1; kcmt_ctx = c;
    step();
  endtask

  initial begin
    do_reset();
    #1;
    chk("R1 fetch_en", 32'(fetch_en), 32'h01);
    chk("R1 copy_req", 32'(copy_req), 0);
    chk("R1 no grant", 32'(spawn_gnt), 0);

    for (int i = 0; i < 9; i++)
      spawn_chk(i == 8 ? "R2 none free" : (i == 1 || i == 3) ? "R3 lowest requester" : "R2 lowest free",
                VEC[i][18:11], VEC[i][10:3], VEC[i][2:0]);
    #1;
    chk("R4 reserved not fetching", 32'(fetch_en), 32'h01);

    sq_vld = 1; sq_ctx = 3'd3;
    step();
    spawn_chk("R7 squashed reused", 8'h01, 8'h01, 3'd3);

    ret_vld = 1; ret_ctx = 3'd1; ret_pc = 32'hBEEF;
    step();
    #1;
    chk("R5 copy_req", 32'(copy_req), 1);
    chk("R5 copy_dst", 32'(copy_dst), 1);
    chk("R5 copy_src", 32'(copy_src), 0);
    chk("R5 copy_pc", copy_pc, 32'hBEEF);
    chk("R6 parent held", 32'(fetch_en), 32'h02);
    step();
    #1;
    chk("R5 copy_req one cycle", 32'(copy_req), 0);
    chk("R6 parent resumes", 32'(fetch_en), 32'h03);

    ret_vld = 1; ret_ctx = 3'd2; ret_pc = 32'h40;
    step();
    #1;
    chk("R5 copy_src thread1", 32'(copy_src), 1);
    chk("R6 thread1 held", 32'(fetch_en), 32'h05);
    step();

    kdec_vld = 1; kdec_ctx = 3'd2;
    step();
    #1;
    chk("R8 kill decode stops fetch", 32'(fetch_en), 32'h03);
    kill_commit(3'd2);
    spawn_chk("R9 killed ctx reused", 8'h01, 8'h01, 3'd2);

    do_reset();
    for (int i = 1; i <= 4; i++)
      spawn_chk("R2 fill", 8'h01, 8'h01, 3'(i));
    kill_commit(3'd1);
    kill_commit(3'd2);
    kill_commit(3'd3);
    spawn_chk("R10 three deaths grant", 8'h01, 8'h01, 3'd1);
    kill_commit(3'd4);
    spawn_chk("R10 four deaths deny", 8'h01, 8'h00, 3'd0);
    for (int i = 0; i < 122; i++) step();
    spawn_chk("R11 still in window", 8'h01, 8'h00, 3'd0);
    spawn_chk("R11 oldest expired", 8'h01, 8'h01, 3'd2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int n = 0; n < 20000; n++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule